// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the serial slave front end of a byte-wide non-volatile memory of 128K x 8. A faster system clock oversamples the serial clock, chip select, data-in and pause pins through synchronizers. The block takes the first byte of each selected frame as an opcode, gathers a 24-bit address where the command needs one, and streams array or status bytes back on the serial output. Array data comes from a synchronous RAM inside the design. A separate write port lets the page-write logic fill that RAM.

Write-type commands are not carried out here. The block reports each accepted command with a start pulse and a command code. It passes every received data byte on with a valid strobe, and it signals the end of the frame when chip select rises. The page-write and status logic act on these events. The serial output is modelled as a data bit plus an enable, and a low enable stands for high impedance at the pad.

The controller is a single state machine:

| State | Meaning |
|---|---|
| S_IDLE | Deselected |
| S_OPCODE | Collecting the opcode |
| S_ADDR | Collecting three address bytes |
| S_STREAM | Array bytes going out |
| S_STATOUT | Status bytes going out |
| S_STATIN | One status byte coming in |
| S_WDATA | Write data coming in |
| S_SINK | Accepted command is complete and further bits are ignored |
| S_LOCK | Rejected opcode, locked out |

Its transitions are:
- Any state moves to S_IDLE when chip select is high.
- S_IDLE moves to S_OPCODE when chip select is low.
- S_OPCODE moves on when the eighth bit arrives:
  - to S_ADDR for an array read or array write;
  - to S_STATOUT for a status read;
  - to S_STATIN for a status write;
  - to S_SINK for write-enable set or clear;
  - to S_LOCK for an invalid opcode, or for any command other than status read while busy.
- S_ADDR moves to S_STREAM or S_WDATA after the third address byte.
- S_STATIN moves to S_SINK after one byte.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset the output enable is low and no start, end or byte strobe has fired.
- R2: While chip select is high, serial clock and data-in edges have no effect and the output enable stays low.
- R3: Data is taken in MSB first on rising serial clock edges. After the eighth bit the opcode is decoded with bit 3 ignored: 0000x110 gives code 1 (enable set), 0000x100 gives code 2 (enable clear), 0000x101 gives code 3 (status read), 0000x001 gives code 4 (status write), 0000x011 gives code 5 (array read) and 0000x010 gives code 6 (array write). An accepted opcode raises cmd_start_o for one cycle with the code on cmd_code_o, and it is never raised in the same cycle as byte_valid_o.
- R4: Any other opcode produces no start pulse, no byte strobe and no output enable until chip select falls again. A later frame is then decoded normally.
- R5: An array read takes a 24-bit address MSB first and drops bits 23:17. The addressed byte is then driven MSB first. Each bit changes on a falling serial clock edge, so it is valid at the next rising edge.
- R6: A continued array read moves to the next address after each byte, and the address wraps from 1FFFF to 00000.
- R7: A status read drives status_i MSB first and reloads it for every further byte.
- R8: An array write puts the 17-bit address on addr_o and strobes each following data byte on byte_o. The output enable stays low throughout, and cmd_end_o pulses once when chip select rises.
- R9: A status write strobes exactly one data byte. Later bytes in the same frame are ignored.
- R10: A change on the pause input takes effect only while the serial clock is low. While paused, the output enable is low, serial clock and data-in are ignored, and the frame resumes intact.
- R11: While busy_i is high, only the status-read opcode is accepted.
- R12: The same frames behave identically whether the serial clock idles low or idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause input, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte from the status block |
| mem_we_i | input | 1 | RAM write strobe from the page-write block |
| mem_waddr_i | input | MEM_AW | RAM write address |
| mem_wdata_i | input | 8 | RAM write data |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable; low means high impedance |
| cmd_start_o | output | 1 | One-cycle pulse when an opcode is accepted |
| cmd_code_o | output | 3 | Code of the accepted command |
| cmd_end_o | output | 1 | One-cycle pulse when chip select rises after an accepted command |
| addr_o | output | ADDR_W | Current byte address |
| byte_valid_o | output | 1 | Strobe for a received data byte |
| byte_o | output | 8 | Received data byte |

## Verification
Each pin passes through two synchronizer flops and one edge detector. Strobes and shift-register updates therefore land three system clocks after the serial clock edge that causes them, and the output enable lands four clocks after it. The bench holds each serial clock phase for eight system clocks. It samples so_o and so_oe_o just before each rising edge, which leaves at least four clocks of margin. The strobes are counted by a monitor on every clock and compared only after chip select has been high for sixteen clocks, so every pulse has arrived by then.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_WR_EN    = 3'd1,
        CMD_WR_DIS   = 3'd2,
        CMD_STAT_RD  = 3'd3,
        CMD_STAT_WR  = 3'd4,
        CMD_ARRAY_RD = 3'd5,
        CMD_ARRAY_WR = 3'd6
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_STREAM,
        S_STATOUT,
        S_STATIN,
        S_WDATA,
        S_SINK,
        S_LOCK
    } fe_state_e;

    // Bit 3 of the opcode is a don't-care.
    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        casez (op)
            8'b0000_?110: c = CMD_WR_EN;
            8'b0000_?100: c = CMD_WR_DIS;
            8'b0000_?101: c = CMD_STAT_RD;
            8'b0000_?001: c = CMD_STAT_WR;
            8'b0000_?011: c = CMD_ARRAY_RD;
            8'b0000_?010: c = CMD_ARRAY_WR;
            default:      c = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_fe_ram.sv
module spi_fe_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store[waddr_i] <= wdata_i;
        rdata_o <= store[raddr_i];
    end

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              hold_n_s,
    input  logic              busy_i,
    input  logic [7:0]        status_i,
    input  logic [7:0]        mem_q_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              holding_o,
    output logic              cmd_start_o,
    output logic [2:0]        cmd_code_o,
    output logic              cmd_end_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o
);

    localparam int ADDR_BYTES = 3;
    localparam int LO_W       = ADDR_W - 8;
    localparam logic [1:0] LAST_ADDR = 2'(ADDR_BYTES - 1);

    fe_state_e         state, state_nx;
    cmd_e              cmd_q, op_dec;
    logic              op_ok;
    logic              sck_d, holding, rise, fall, byte_done, sending;
    logic [2:0]        bit_cnt;
    logic [1:0]        addr_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        rx_byte, tx_sr, byte_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              tx_live, load_pend, cmd_open;
    logic              so_oe_q, cmd_start_q, cmd_end_q, byte_valid_q;

    assign rise      = cs_act & ~holding & sck_s & ~sck_d;
    assign fall      = cs_act & ~holding & ~sck_s & sck_d;
    assign rx_byte   = {rx_sr, si_s};
    assign byte_done = rise && (bit_cnt == 3'd7);
    assign sending   = (state == S_STREAM) || (state == S_STATOUT);

    // Next-state logic
    always_comb begin
        op_dec   = decode_op(rx_byte);
        op_ok    = (op_dec != CMD_NONE) && (!busy_i || op_dec == CMD_STAT_RD);
        state_nx = state;
        if (!cs_act) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:   state_nx = S_OPCODE;
                S_OPCODE: if (byte_done) begin
                    if (!op_ok) state_nx = S_LOCK;
                    else begin
                        case (op_dec)
                            CMD_ARRAY_RD, CMD_ARRAY_WR: state_nx = S_ADDR;
                            CMD_STAT_RD:                state_nx = S_STATOUT;
                            CMD_STAT_WR:                state_nx = S_STATIN;
                            default:                    state_nx = S_SINK;
                        endcase
                    end
                end
                S_ADDR:   if (byte_done && addr_cnt == LAST_ADDR)
                    state_nx = (cmd_q == CMD_ARRAY_RD) ? S_STREAM : S_WDATA;
                S_STATIN: if (byte_done) state_nx = S_SINK;
                S_STREAM, S_STATOUT, S_WDATA, S_SINK, S_LOCK: state_nx = state;
                default:  state_nx = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d        <= 1'b0;
            holding      <= 1'b0;
            bit_cnt      <= '0;
            addr_cnt     <= '0;
            rx_sr        <= '0;
            tx_sr        <= '0;
            byte_q       <= '0;
            cur_addr     <= '0;
            cmd_q        <= CMD_NONE;
            tx_live      <= 1'b0;
            load_pend    <= 1'b0;
            cmd_open     <= 1'b0;
            so_oe_q      <= 1'b0;
            cmd_start_q  <= 1'b0;
            cmd_end_q    <= 1'b0;
            byte_valid_q <= 1'b0;
        end else begin
            cmd_start_q  <= 1'b0;
            cmd_end_q    <= 1'b0;
            byte_valid_q <= 1'b0;
            sck_d        <= sck_s;
            if (!cs_act)     holding <= 1'b0;
            else if (!sck_s) holding <= ~hold_n_s;
            so_oe_q <= cs_act && tx_live && !holding && sending;

            if (!cs_act || state == S_IDLE) begin
                bit_cnt   <= '0;
                addr_cnt  <= '0;
                tx_live   <= 1'b0;
                load_pend <= 1'b0;
                if (!cs_act) begin
                    if (cmd_open) cmd_end_q <= 1'b1;
                    cmd_open <= 1'b0;
                end
            end else begin
                if (rise) begin
                    rx_sr   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (byte_done) begin
                    case (state)
                        S_OPCODE: if (op_ok) begin
                            cmd_q       <= op_dec;
                            cmd_start_q <= 1'b1;
                            cmd_open    <= 1'b1;
                            if (op_dec == CMD_STAT_RD) load_pend <= 1'b1;
                        end
                        S_ADDR: begin
                            cur_addr <= {cur_addr[LO_W-1:0], rx_byte};
                            addr_cnt <= addr_cnt + 2'd1;
                            if (addr_cnt == LAST_ADDR && cmd_q == CMD_ARRAY_RD)
                                load_pend <= 1'b1;
                        end
                        S_STREAM: begin
                            cur_addr  <= cur_addr + 1'b1;
                            load_pend <= 1'b1;
                        end
                        S_STATOUT: load_pend <= 1'b1;
                        S_WDATA, S_STATIN: begin
                            byte_q       <= rx_byte;
                            byte_valid_q <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (fall && sending) begin
                    if (load_pend) begin
                        tx_sr     <= (state == S_STREAM) ? mem_q_i : status_i;
                        load_pend <= 1'b0;
                        tx_live   <= 1'b1;
                    end else begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign so_o         = tx_sr[7];
    assign so_oe_o      = so_oe_q;
    assign holding_o    = holding;
    assign cmd_start_o  = cmd_start_q;
    assign cmd_code_o   = cmd_q;
    assign cmd_end_o    = cmd_end_q;
    assign addr_o       = cur_addr;
    assign byte_valid_o = byte_valid_q;
    assign byte_o       = byte_q;

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
    parameter int ADDR_W      = 17,
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    input  logic              busy_i,
    input  logic [7:0]        status_i,
    input  logic              mem_we_i,
    input  logic [MEM_AW-1:0] mem_waddr_i,
    input  logic [7:0]        mem_wdata_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              cmd_start_o,
    output logic [2:0]        cmd_code_o,
    output logic              cmd_end_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o
);

    localparam int PINS = 4;

    logic [PINS-1:0] pins_raw, pins_s;
    logic            cs_act, holding;
    logic [7:0]      mem_q;

    assign pins_raw = {cs_n_i, sck_i, si_i, hold_n_i};

    spi_fe_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pins_raw),
        .q_o  (pins_s)
    );

    assign cs_act = ~pins_s[3];

    spi_fe_ram #(
        .AW(MEM_AW),
        .DW(8)
    ) u_ram (
        .clk    (clk),
        .we_i   (mem_we_i),
        .waddr_i(mem_waddr_i),
        .wdata_i(mem_wdata_i),
        .raddr_i(addr_o[MEM_AW-1:0]),
        .rdata_o(mem_q)
    );

    spi_fe_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (cs_act),
        .sck_s       (pins_s[2]),
        .si_s        (pins_s[1]),
        .hold_n_s    (pins_s[0]),
        .busy_i      (busy_i),
        .status_i    (status_i),
        .mem_q_i     (mem_q),
        .so_o        (so_o),
        .so_oe_o     (so_oe_o),
        .holding_o   (holding),
        .cmd_start_o (cmd_start_o),
        .cmd_code_o  (cmd_code_o),
        .cmd_end_o   (cmd_end_o),
        .addr_o      (addr_o),
        .byte_valid_o(byte_valid_o),
        .byte_o      (byte_o)
    );

endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_act,
    input logic       holding,
    input logic       busy_i,
    input logic       so_oe_o,
    input logic       cmd_start_o,
    input logic [2:0] cmd_code_o,
    input logic       byte_valid_o
);

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_oe_o);

    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holding |=> !so_oe_o);

    // R11
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o && $past(busy_i) |-> cmd_code_o == 3'd3);

    // R3
    start_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start_o |-> cmd_code_o != 3'd0);

    // R8
    rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> !so_oe_o);

    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_start_o, byte_valid_o}));

endmodule

bind spi_mem_frontend spi_fe_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .holding     (holding),
    .busy_i      (busy_i),
    .so_oe_o     (so_oe_o),
    .cmd_start_o (cmd_start_o),
    .cmd_code_o  (cmd_code_o),
    .byte_valid_o(byte_valid_o)
);

// File: tb/spi_mem_frontend_test.sv
`timescale 1ns/1ps
module spi_mem_frontend_test;

    localparam int ADDR_W = 17;
    localparam int MEM_AW = 10;
    localparam int H      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0] status = 8'h00;
    logic mem_we = 1'b0;
    logic [MEM_AW-1:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;
    logic so, so_oe, cmd_start, cmd_end, byte_valid;
    logic [2:0] cmd_code;
    logic [ADDR_W-1:0] addr;
    logic [7:0] byte_d;

    always #10 clk = ~clk;

    spi_mem_frontend #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .hold_n_i(hold_n), .busy_i(busy), .status_i(status),
        .mem_we_i(mem_we), .mem_waddr_i(mem_waddr), .mem_wdata_i(mem_wdata),
        .so_o(so), .so_oe_o(so_oe), .cmd_start_o(cmd_start), .cmd_code_o(cmd_code),
        .cmd_end_o(cmd_end), .addr_o(addr), .byte_valid_o(byte_valid), .byte_o(byte_d));

    int checks = 0, failures = 0;
    int n_start = 0, n_end = 0, n_byte = 0, n_oe = 0;
    logic [2:0] last_code = 3'd0;
    logic [7:0] byte_log [0:7];
    logic mode3 = 1'b0;
    logic hold_oe_seen = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (cmd_start) begin n_start++; last_code = cmd_code; end
        if (cmd_end) n_end++;
        if (byte_valid) begin byte_log[n_byte % 8] = byte_d; n_byte++; end
        if (so_oe) n_oe++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        sck = mode3;
        wait_clk(H);
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_end();
        if (!mode3) sck = 1'b0;
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_bit,
                        output logic [7:0] rx, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            if (i == hold_bit) begin
                wait_clk(H);
                hold_n = 1'b0;
                wait_clk(H);
                if (so_oe) hold_oe_seen = 1'b1;
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; si = ~si; wait_clk(H);
                    if (so_oe) hold_oe_seen = 1'b1;
                    sck = 1'b0; wait_clk(H);
                end
                si = tx[i];
                hold_n = 1'b1;
            end
            wait_clk(H);
            rx[i] = so;
            if (!so_oe) oe_all = 1'b0;
            sck = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r;
        logic o;
        xfer(tx, -1, r, o);
    endtask

    task automatic mem_load(input logic [MEM_AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    // {opcode, expected code}; code 0 means rejected
    localparam logic [15:0] OP_VEC [0:10] = '{
        16'h0601, 16'h0E01, 16'h0402, 16'h0503, 16'h0104, 16'h0305,
        16'h0206, 16'h0B05, 16'h0700, 16'hFF00, 16'h1600 };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r, r2;
        logic o, o2;
        int s0, e0, b0, oe0;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        chk("R1 oe after reset", so_oe, 0);
        chk("R1 no strobes after reset", n_start + n_end + n_byte, 0);

        mem_load(10'h3FF, 8'hA5);
        mem_load(10'h000, 8'h3C);
        mem_load(10'h001, 8'hC3);
        mem_load(10'h012, 8'h5A);
        mem_load(10'h013, 8'hE7);

        // Opcode vector table: R3 accepted, R4 rejected
        foreach (OP_VEC[v]) begin
            s0 = n_start;
            cs_begin();
            send(OP_VEC[v][15:8]);
            cs_end();
            if (OP_VEC[v][7:0] == 8'd0)
                chk("R4 rejected opcode start count", n_start - s0, 0);
            else begin
                chk("R3 opcode start count", n_start - s0, 1);
                chk("R3 opcode code", last_code, OP_VEC[v][7:0]);
            end
        end

        // R2: toggles while deselected
        s0 = n_start; oe0 = n_oe;
        for (int i = 7; i >= 0; i--) begin
            si = (8'h05 >> i) & 1'b1;
            sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
        end
        chk("R2 no start while deselected", n_start - s0, 0);
        chk("R2 oe while deselected", n_oe - oe0, 0);

        // R5: address with high bits set, bits 23:17 dropped
        cs_begin();
        send(8'h03); send(8'hFE); send(8'h00); send(8'h12);
        xfer(8'h00, -1, r, o);
        chk("R5 first read byte", r, 8'h5A);
        chk("R5 oe during read", o, 1);
        xfer(8'hFF, -1, r, o);
        chk("R6 next read byte", r, 8'hE7);
        cs_end();

        // R6: wrap from 1FFFF
        cs_begin();
        send(8'h03); send(8'h01); send(8'hFF); send(8'hFF);
        xfer(8'h00, -1, r, o);
        chk("R6 top byte", r, 8'hA5);
        xfer(8'h00, -1, r, o);
        chk("R6 wrapped to 00000", r, 8'h3C);
        xfer(8'h00, -1, r, o);
        chk("R6 address 00001", r, 8'hC3);
        cs_end();
        chk("R2 oe drops after deselect", so_oe, 0);

        // R7: status read repeats
        status = 8'h8E;
        cs_begin();
        send(8'h05);
        xfer(8'h00, -1, r, o);
        xfer(8'h00, -1, r2, o2);
        cs_end();
        chk("R7 status byte 1", r, 8'h8E);
        chk("R7 status byte 2", r2, 8'h8E);
        chk("R7 oe during status", o & o2, 1);

        // R8: array write handoff
        s0 = n_start; e0 = n_end; b0 = n_byte; oe0 = n_oe;
        cs_begin();
        send(8'h02); send(8'h01); send(8'h23); send(8'h45);
        send(8'h11); send(8'h22);
        chk("R8 no end before deselect", n_end - e0, 0);
        cs_end();
        chk("R8 address", addr, 17'h12345);
        chk("R8 byte count", n_byte - b0, 2);
        chk("R8 first byte", byte_log[b0 % 8], 8'h11);
        chk("R8 second byte", byte_log[(b0 + 1) % 8], 8'h22);
        chk("R8 one end pulse", n_end - e0, 1);
        chk("R8 oe low during write", n_oe - oe0, 0);

        // R9: status write takes one byte
        b0 = n_byte;
        cs_begin();
        send(8'h01); send(8'h8C); send(8'h77);
        cs_end();
        chk("R9 byte count", n_byte - b0, 1);
        chk("R9 byte value", byte_log[b0 % 8], 8'h8C);

        // R4: lockout then recovery
        s0 = n_start; b0 = n_byte; oe0 = n_oe;
        cs_begin();
        send(8'h07); send(8'h02); send(8'h06);
        cs_end();
        chk("R4 no start after invalid", n_start - s0, 0);
        chk("R4 no bytes after invalid", n_byte - b0, 0);
        chk("R4 oe low after invalid", n_oe - oe0, 0);
        cs_begin();
        send(8'h06);
        cs_end();
        chk("R4 recovery start", n_start - s0, 1);

        // R11: busy gating
        busy = 1'b1;
        s0 = n_start;
        cs_begin();
        send(8'h02); send(8'h00);
        cs_end();
        chk("R11 write ignored while busy", n_start - s0, 0);
        status = 8'hFF;
        cs_begin();
        send(8'h05);
        xfer(8'h00, -1, r, o);
        cs_end();
        chk("R11 status read while busy", n_start - s0, 1);
        chk("R11 status value while busy", r, 8'hFF);
        busy = 1'b0;

        // R10: pause in the middle of a data byte
        hold_oe_seen = 1'b0;
        cs_begin();
        send(8'h03); send(8'h00); send(8'h00); send(8'h12);
        xfer(8'h00, 4, r, o);
        xfer(8'h00, -1, r2, o2);
        cs_end();
        chk("R10 oe during pause", hold_oe_seen, 0);
        chk("R10 byte intact across pause", r, 8'h5A);
        chk("R10 oe after resume", o, 1);
        chk("R10 sequence continues", r2, 8'hE7);

        // R12: clock idling high
        mode3 = 1'b1;
        cs_begin();
        send(8'h03); send(8'h01); send(8'hFF); send(8'hFF);
        xfer(8'h00, -1, r, o);
        xfer(8'h00, -1, r2, o2);
        cs_end();
        chk("R12 idle-high read byte", r, 8'hA5);
        chk("R12 idle-high wrap byte", r2, 8'h3C);
        status = 8'h42;
        cs_begin();
        send(8'h0D);
        xfer(8'h00, -1, r, o);
        cs_end();
        chk("R12 idle-high status read", r, 8'h42);
        mode3 = 1'b0;
        sck = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule